// File: doc/BRIEF.md
# Optical Port Pin Conditioner

This block sits between an infrared serial port and its two pins and decides what each pin carries. On the transmit side, a two-bit select field picks the source for the output pin. The choices are the serial transmit data, a general-purpose output bit, or one of two metering pulse trains (watt and var). Serial transmit data can be inverted. It can also be modulated with a carrier: the carrier fills in every stretch where the inverted-or-not data would be low. The output pin is driven from a register, so switching the select, the carrier or the data never produces a glitch.

On the receive side, the block takes the comparator result bit and uses it in one of two ways. It either feeds the serial receiver, optionally inverted, or it is handed to a general-purpose digital input, with the inversion not applied. While the pin is in digital-input mode, the serial receive line rests at its idle level of 1. All configuration sits in one six-bit register behind a plain parallel write/read port. The comparator, the carrier oscillator and the serial engine are outside the block.

Top module: `optpin_cfg`

## Requirements
- R1: While reset is active, the configuration register reads 0 and the transmit pin is 1.
- R2: A write with `cfg_we` high loads `cfg_wdata` into the configuration register at the clock edge, and `cfg_rdata` returns it. The field layout is bits 1:0 transmit select, bit 2 transmit invert, bit 3 modulation enable, bit 4 receive disable, and bit 5 receive invert.
- R3: The transmit select maps 00 to serial data, 01 to the general-purpose output bit, 10 to the watt pulse and 11 to the var pulse. The pin shows the chosen source one clock edge after it is sampled.
- R4: With select 00 and the invert bit set, the pin carries the complement of the serial data. Inversion is applied before modulation.
- R5: With select 00 and modulation enabled, the pin follows the carrier wherever the post-inversion data is 0, and is 1 wherever that data is 1.
- R6: Invert and modulation have no effect when select is 01, 10 or 11.
- R7: With receive disable 0, `uart_rxd` equals the comparator bit XOR receive invert, and `gpio_rx_in` is 0.
- R8: With receive disable 1, `uart_rxd` is 1 and `gpio_rx_in` equals the comparator bit unmodified, whatever the receive invert bit holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 6 | Configuration write data |
| cfg_rdata | output | 6 | Configuration read data |
| uart_txd | input | 1 | Serial transmit data |
| gpio_tx_out | input | 1 | General-purpose output bit |
| watt_pulse | input | 1 | Watt metering pulse |
| var_pulse | input | 1 | Var metering pulse |
| carrier | input | 1 | Free-running carrier square wave |
| opt_tx_pin | output | 1 | Registered transmit pin drive |
| rx_comp | input | 1 | Receive comparator result |
| uart_rxd | output | 1 | Serial receive input |
| gpio_rx_in | output | 1 | General-purpose digital input |

## Verification
The transmit path is driven through every combination of data level, carrier level, invert and modulation under serial select. These cases separate inversion-before-modulation from the reverse order: with invert and modulation both set and the data high, the carrier must show, not a constant. Each non-serial select is tried with invert and modulation set and the carrier high, so a path that leaks shaping into the wrong source stands out. On the receive side, both comparator levels are tried under each mode with receive invert both set and clear. This tells inversion on the serial path apart from inversion on the digital input.

// File: rtl/optpin_pkg.sv
package optpin_pkg;
  typedef enum logic [1:0] {
    TXS_UART = 2'b00,
    TXS_GPIO = 2'b01,
    TXS_WATT = 2'b10,
    TXS_VAR  = 2'b11
  } tx_sel_e;

  typedef struct packed {
    logic    rx_inv;
    logic    rx_dis;
    logic    tx_mod;
    logic    tx_inv;
    tx_sel_e tx_sel;
  } optcfg_t;

  localparam int CFG_W = $bits(optcfg_t);

  // Serial data shaping: invert first, then fill low stretches with carrier.
  function automatic logic tx_shape(input logic d, input logic inv,
                                    input logic mod, input logic car);
    logic p;
    p = d ^ inv;
    return p | (mod & car);
  endfunction

  function automatic logic rx_shape(input logic comp, input logic inv,
                                    input logic dis);
    return dis ? 1'b1 : (comp ^ inv);
  endfunction
endpackage

// File: rtl/optpin_regs.sv
module optpin_regs
  import optpin_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] rdata,
  output optcfg_t          cfg
);
  always_ff @(posedge clk) begin
    if (!rst_n)  cfg <= '0;
    else if (we) cfg <= optcfg_t'(wdata);
  end

  assign rdata = CFG_W'(cfg);
endmodule

// File: rtl/optpin_tx.sv
module optpin_tx
  import optpin_pkg::*;
#(
  parameter logic RESET_LEVEL = 1'b1
) (
  input  logic    clk,
  input  logic    rst_n,
  input  optcfg_t cfg,
  input  logic    uart_txd,
  input  logic    gpio_tx_out,
  input  logic    watt_pulse,
  input  logic    var_pulse,
  input  logic    carrier,
  output logic    pin
);
  localparam int NSRC = 4;
  logic [NSRC-1:0] src;
  logic            shaped;
  logic            pin_nxt;

  assign shaped = tx_shape(uart_txd, cfg.tx_inv, cfg.tx_mod, carrier);

  // Source table indexed by the select encoding.
  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_src
      if (i == int'(TXS_UART))      begin : g_u assign src[i] = shaped;      end
      else if (i == int'(TXS_GPIO)) begin : g_g assign src[i] = gpio_tx_out; end
      else if (i == int'(TXS_WATT)) begin : g_w assign src[i] = watt_pulse;  end
      else                          begin : g_v assign src[i] = var_pulse;   end
    end
  endgenerate

  assign pin_nxt = src[cfg.tx_sel];

  always_ff @(posedge clk) begin
    if (!rst_n) pin <= RESET_LEVEL;
    else        pin <= pin_nxt;
  end
endmodule

// File: rtl/optpin_rx.sv
module optpin_rx
  import optpin_pkg::*;
(
  input  optcfg_t cfg,
  input  logic    rx_comp,
  output logic    uart_rxd,
  output logic    gpio_rx_in
);
  assign uart_rxd   = rx_shape(rx_comp, cfg.rx_inv, cfg.rx_dis);
  assign gpio_rx_in = cfg.rx_dis & rx_comp;
endmodule

// File: rtl/optpin_cfg.sv
module optpin_cfg
  import optpin_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             uart_txd,
  input  logic             gpio_tx_out,
  input  logic             watt_pulse,
  input  logic             var_pulse,
  input  logic             carrier,
  output logic             opt_tx_pin,
  input  logic             rx_comp,
  output logic             uart_rxd,
  output logic             gpio_rx_in
);
  optcfg_t cfg;
  // Named configuration wires for the checker.
  logic [1:0] cfg_sel_w;
  logic       cfg_inv_w, cfg_mod_w, cfg_rxdis_w, cfg_rxinv_w;
  assign cfg_sel_w   = cfg.tx_sel;
  assign cfg_inv_w   = cfg.tx_inv;
  assign cfg_mod_w   = cfg.tx_mod;
  assign cfg_rxdis_w = cfg.rx_dis;
  assign cfg_rxinv_w = cfg.rx_inv;

  optpin_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .cfg(cfg)
  );

  optpin_tx #(.RESET_LEVEL(1'b1)) u_tx (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .uart_txd(uart_txd),
    .gpio_tx_out(gpio_tx_out), .watt_pulse(watt_pulse),
    .var_pulse(var_pulse), .carrier(carrier), .pin(opt_tx_pin)
  );

  optpin_rx u_rx (
    .cfg(cfg), .rx_comp(rx_comp), .uart_rxd(uart_rxd),
    .gpio_rx_in(gpio_rx_in)
  );
endmodule

// File: rtl/optpin_chk.sv
module optpin_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] sel,
  input logic       inv,
  input logic       mod,
  input logic       rxdis,
  input logic       rxinv,
  input logic       uart_txd,
  input logic       gpio_tx_out,
  input logic       watt_pulse,
  input logic       var_pulse,
  input logic       carrier,
  input logic       opt_tx_pin,
  input logic       rx_comp,
  input logic       uart_rxd,
  input logic       gpio_rx_in,
  input logic [5:0] cfg_rdata
);
  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (opt_tx_pin && cfg_rdata == 6'd0));

  a_r4_uart_invert: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'b00 && !mod) |=> opt_tx_pin == ($past(uart_txd) ^ $past(inv)));

  a_r5_mod_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'b00 && mod && (uart_txd != inv)) |=> opt_tx_pin);

  a_r5_mod_carrier: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'b00 && mod && (uart_txd == inv)) |=> opt_tx_pin == $past(carrier));

  a_r3_gpio_src: assert property (@(posedge clk) disable iff (!rst_n)
    sel == 2'b01 |=> opt_tx_pin == $past(gpio_tx_out));

  a_r6_watt_raw: assert property (@(posedge clk) disable iff (!rst_n)
    sel == 2'b10 |=> opt_tx_pin == $past(watt_pulse));

  a_r6_var_raw: assert property (@(posedge clk) disable iff (!rst_n)
    sel == 2'b11 |=> opt_tx_pin == $past(var_pulse));

  a_r8_rx_idle: assert property (@(posedge clk) disable iff (!rst_n)
    rxdis |-> (uart_rxd && gpio_rx_in == rx_comp));

  a_r7_rx_uart: assert property (@(posedge clk) disable iff (!rst_n)
    !rxdis |-> (!gpio_rx_in && uart_rxd == (rxinv ? !rx_comp : rx_comp)));
endmodule

bind optpin_cfg optpin_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sel(cfg_sel_w), .inv(cfg_inv_w),
  .mod(cfg_mod_w), .rxdis(cfg_rxdis_w), .rxinv(cfg_rxinv_w),
  .uart_txd(uart_txd), .gpio_tx_out(gpio_tx_out), .watt_pulse(watt_pulse),
  .var_pulse(var_pulse), .carrier(carrier), .opt_tx_pin(opt_tx_pin),
  .rx_comp(rx_comp), .uart_rxd(uart_rxd), .gpio_rx_in(gpio_rx_in),
  .cfg_rdata(cfg_rdata)
);

// File: tb/tb_optpin_cfg.sv
module tb_optpin_cfg;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 16;
  // {cfg[5:0], uart, gpio, watt, var, carrier, expected pin}
  localparam logic [11:0] VEC [NV] = '{
    {6'b000000, 5'b10000, 1'b1},
    {6'b000000, 5'b01111, 1'b0},
    {6'b000100, 5'b00000, 1'b1},
    {6'b000100, 5'b10000, 1'b0},
    {6'b001000, 5'b00001, 1'b1},
    {6'b001000, 5'b00000, 1'b0},
    {6'b001000, 5'b10000, 1'b1},
    {6'b001100, 5'b10001, 1'b1},
    {6'b001100, 5'b10000, 1'b0},
    {6'b001100, 5'b00000, 1'b1},
    {6'b000001, 5'b01000, 1'b1},
    {6'b001101, 5'b10001, 1'b0},
    {6'b000010, 5'b00100, 1'b1},
    {6'b001110, 5'b00001, 1'b0},
    {6'b000011, 5'b00010, 1'b1},
    {6'b001111, 5'b00001, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0, cfg_we = 1'b0;
  logic [5:0] cfg_wdata = '0, cfg_rdata;
  logic uart_txd = 1'b0, gpio_tx_out = 1'b0, watt_pulse = 1'b0;
  logic var_pulse = 1'b0, carrier = 1'b0, rx_comp = 1'b0;
  logic opt_tx_pin, uart_rxd, gpio_rx_in;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  optpin_cfg dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .uart_txd(uart_txd), .gpio_tx_out(gpio_tx_out),
    .watt_pulse(watt_pulse), .var_pulse(var_pulse), .carrier(carrier),
    .opt_tx_pin(opt_tx_pin), .rx_comp(rx_comp), .uart_rxd(uart_rxd),
    .gpio_rx_in(gpio_rx_in)
  );

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [5:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic string tag_of(input logic [5:0] c);
    if (c[1:0] != 2'b00) return (c[3] | c[2]) ? "R6" : "R3";
    if (c[3]) return "R5";
    if (c[2]) return "R4";
    return "R3";
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", cfg_rdata, 6'd0);          // R1 register reset
    check("R1", {5'd0, opt_tx_pin}, 6'd1); // R1 pin idle high
    rst_n = 1'b1;
    @(negedge clk);

    // R2 read-back of a written pattern
    write_cfg(6'b101010);
    check("R2", cfg_rdata, 6'b101010);
    write_cfg(6'b010101);
    check("R2", cfg_rdata, 6'b010101);

    for (int i = 0; i < NV; i++) begin
      write_cfg(VEC[i][11:6]);
      {uart_txd, gpio_tx_out, watt_pulse, var_pulse, carrier} = VEC[i][5:1];
      @(posedge clk); @(negedge clk);
      check(tag_of(VEC[i][11:6]), {5'd0, opt_tx_pin}, {5'd0, VEC[i][0]});
    end

    // R5 carrier toggling is followed one edge later
    write_cfg(6'b001000);
    uart_txd = 1'b0;
    for (int k = 0; k < 4; k++) begin
      carrier = k[0];
      @(posedge clk); @(negedge clk);
      check("R5", {5'd0, opt_tx_pin}, {5'd0, k[0]});
    end

    // R7 receive to serial path, plain and inverted
    for (int m = 0; m < 4; m++) begin
      write_cfg({m[1], 5'b00000});
      rx_comp = m[0]; #1;
      check("R7", {4'd0, uart_rxd, gpio_rx_in}, {4'd0, m[0] ^ m[1], 1'b0});
    end
    // R8 digital-input mode ignores receive invert
    for (int m = 0; m < 4; m++) begin
      write_cfg({m[1], 5'b10000});
      rx_comp = m[0]; #1;
      check("R8", {4'd0, uart_rxd, gpio_rx_in}, {4'd0, 1'b1, m[0]});
    end

    // R1 reset mid-run clears configuration and returns pin high
    write_cfg(6'b111101);
    gpio_tx_out = 1'b0;
    rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R1", {cfg_rdata[5:1], opt_tx_pin}, 6'b000001);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule